// File: doc/BRIEF.md
# Nibble Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for two small unsigned operands. A group-select input picks one of two operation groups, and a two-bit code picks one of four operations inside that group. The arithmetic group holds wrap-around addition, wrap-around subtraction and a one-place rotation of the first operand in either direction. The logic group holds the four bitwise functions AND, OR, XOR and XNOR.

The result and a carry/borrow flag settle in the same cycle as the inputs, so the unit can sit between pipeline registers of a larger datapath. The operand width is a parameter with a default of four bits. All operation codes are fixed.

Top module: `nib_alu`

## Requirements
- R1: `grp_sel` = 0 selects the arithmetic group and `grp_sel` = 1 selects the logic group. Within the chosen group, `op_code` picks the operation as listed in R2 to R6.
- R2: Arithmetic code 00 drives `result` with (opa + opb) mod 2^W. `carry_out` is the bit carried out of the top bit, so {carry_out, result} equals the full sum.
- R3: Arithmetic code 01 drives `result` with (opa - opb) mod 2^W. `carry_out` is 1 exactly when opa < opb, taken as unsigned values (a borrow).
- R4: Arithmetic code 10 rotates opa left by one place: the old top bit enters bit 0. The value of opb has no effect on either output, and `carry_out` is 0.
- R5: Arithmetic code 11 rotates opa right by one place: the old bit 0 enters the top bit. The value of opb has no effect on either output, and `carry_out` is 0.
- R6: Logic codes drive `result` with the bitwise function of opa and opb: 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives XNOR.
- R7: In the logic group `carry_out` is 0.
- R8: Both outputs are combinational: they take the value for the current inputs within the same clock cycle, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (4) | First operand; the only source for rotations |
| opb | input | W (4) | Second operand |
| grp_sel | input | 1 | 0 = arithmetic group, 1 = logic group |
| op_code | input | 2 | Operation within the selected group |
| result | output | W (4) | Operation result |
| carry_out | output | 1 | Carry of add, borrow of subtract, else 0 |

## Verification
The bench builds the unit with its default width of four bits. At that width there are only 256 operand pairs, so all of them are swept for each of the eight operations. Every carry, borrow and rotation wrap case is therefore covered, and no corner is left to chance. Constrained random patterns and a directed check of how opb affects rotations are added on top. Each pattern is applied and sampled within a single cycle, which exercises the combinational timing of R8.

// File: rtl/nib_alu_pkg.sv
`timescale 1ns/1ps
package nib_alu_pkg;
  typedef enum logic [1:0] {
    AR_ADD = 2'b00,
    AR_SUB = 2'b01,
    AR_ROL = 2'b10,
    AR_ROR = 2'b11
  } arith_op_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_XNOR = 2'b11
  } logic_op_e;

  localparam logic GRP_ARITH = 1'b0;
  localparam logic GRP_LOGIC = 1'b1;
endpackage

// File: rtl/nib_alu_arith.sv
`timescale 1ns/1ps
module nib_alu_arith
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   code_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  localparam int WX = W + 1;

  logic [WX-1:0] sum_x;
  logic [WX-1:0] dif_x;
  logic [W-1:0]  rol_v;
  logic [W-1:0]  ror_v;

  assign sum_x = {1'b0, a_i} + {1'b0, b_i};
  assign dif_x = {1'b0, a_i} - {1'b0, b_i};
  assign rol_v = {a_i[W-2:0], a_i[W-1]};
  assign ror_v = {a_i[0], a_i[W-1:1]};

  always_comb begin
    res_o = '0;
    cy_o  = 1'b0;
    unique case (arith_op_e'(code_i))
      AR_ADD: begin res_o = sum_x[W-1:0]; cy_o = sum_x[W]; end
      AR_SUB: begin res_o = dif_x[W-1:0]; cy_o = dif_x[W]; end
      AR_ROL: res_o = rol_v;
      AR_ROR: res_o = ror_v;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/nib_alu_logic.sv
`timescale 1ns/1ps
module nib_alu_logic
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   code_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic x_v;
    assign x_v = a_i[i] ^ b_i[i];
    always_comb begin
      unique case (logic_op_e'(code_i))
        LG_AND:  res_o[i] = a_i[i] & b_i[i];
        LG_OR:   res_o[i] = a_i[i] | b_i[i];
        LG_XOR:  res_o[i] = x_v;
        LG_XNOR: res_o[i] = ~x_v;
        default: res_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nib_alu.sv
`timescale 1ns/1ps
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         grp_sel,
  input  logic [1:0]   op_code,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic [W-1:0] ar_res;
  logic         ar_cy;
  logic [W-1:0] lg_res;

  nib_alu_arith #(.W(W)) u_arith (
    .a_i    (opa),
    .b_i    (opb),
    .code_i (op_code),
    .res_o  (ar_res),
    .cy_o   (ar_cy)
  );

  nib_alu_logic #(.W(W)) u_logic (
    .a_i    (opa),
    .b_i    (opb),
    .code_i (op_code),
    .res_o  (lg_res)
  );

  always_comb begin
    if (grp_sel == GRP_LOGIC) begin
      result    = lg_res;
      carry_out = 1'b0;
    end else begin
      result    = ar_res;
      carry_out = ar_cy;
    end
  end
endmodule

// File: rtl/nib_alu_chk.sv
`timescale 1ns/1ps
module nib_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         grp_sel,
  input logic [1:0]   op_code,
  input logic [W-1:0] result,
  input logic         carry_out
);
  logic [W:0] full_sum;
  assign full_sum = {1'b0, opa} + {1'b0, opb};

  always_comb begin
    if (!grp_sel && op_code == 2'b00)
      p_add_sum_r2: assert ({carry_out, result} == full_sum);
    if (!grp_sel && op_code == 2'b01)
      p_sub_borrow_r3: assert (carry_out == (opa < opb) && W'(result + opb) == opa);
    if (!grp_sel && op_code == 2'b10)
      p_rol_wrap_r4: assert (result[0] == opa[W-1] && !carry_out);
    if (!grp_sel && op_code == 2'b11)
      p_ror_wrap_r5: assert (result[W-1] == opa[0] && !carry_out);
    if (grp_sel && op_code == 2'b11)
      p_xnor_r6: assert ((result ^ opa ^ opb) == {W{1'b1}});
    if (grp_sel)
      p_no_carry_r7: assert (!carry_out);
  end
endmodule

bind nib_alu nib_alu_chk #(.W(W)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .grp_sel   (grp_sel),
  .op_code   (op_code),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/nib_alu_bench.sv
`timescale 1ns/1ps
module nib_alu_bench;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk;
  logic [W-1:0] opa, opb;
  logic         grp_sel;
  logic [1:0]   op_code;
  logic [W-1:0] result;
  logic         carry_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  nib_alu #(.W(W)) u_nib_alu (
    .opa(opa), .opb(opb), .grp_sel(grp_sel), .op_code(op_code),
    .result(result), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W:0] expect_of(logic g, logic [1:0] c,
                                           logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] r;
    if (!g) begin
      case (c)
        2'b00: r = {1'b0, a} + {1'b0, b};
        2'b01: r = {(a < b), W'(a - b)};
        2'b10: r = {1'b0, a[W-2:0], a[W-1]};
        default: r = {1'b0, a[0], a[W-1:1]};
      endcase
    end else begin
      case (c)
        2'b00: r = {1'b0, a & b};
        2'b01: r = {1'b0, a | b};
        2'b10: r = {1'b0, a ^ b};
        default: r = {1'b0, ~(a ^ b)};
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(logic g, logic [1:0] c);
    if (g) return "R6/R7";
    case (c)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [W:0] got, logic [W:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got {cy,res}=%b expected %b (g=%0b c=%b a=%h b=%h)",
               tag, got, exp, grp_sel, op_code, opa, opb);
    end
  endtask

  task automatic apply(logic g, logic [1:0] c, logic [W-1:0] a, logic [W-1:0] b);
    @(posedge clk);
    grp_sel = g; op_code = c; opa = a; opb = b;
    @(negedge clk);
    check(tag_of(g, c), {carry_out, result}, expect_of(g, c, a, b));
  endtask

  initial begin
    logic [W:0] first;
    void'($urandom(32'd1234));
    grp_sel = 1'b0; op_code = 2'b00; opa = '0; opb = '0;
    // R8: the value for the current inputs shows in the same half cycle
    #1;
    check("R8", {carry_out, result}, '0);
    opa = 4'h9; opb = 4'h8;
    #1;
    check("R8", {carry_out, result}, 5'b1_0001);
    // R1: the same operands and code give different results in the two groups
    apply(1'b0, 2'b10, 4'hC, 4'h3);
    check("R1", {carry_out, result}, 5'b0_1001);
    apply(1'b1, 2'b10, 4'hC, 4'h3);
    check("R1", {carry_out, result}, 5'b0_1111);
    // Directed corners for R2, R3 and R6
    apply(1'b0, 2'b00, 4'hF, 4'h1);
    check("R2", {carry_out, result}, 5'b1_0000);
    apply(1'b0, 2'b01, 4'h0, 4'h1);
    check("R3", {carry_out, result}, 5'b1_1111);
    apply(1'b0, 2'b01, 4'h5, 4'h5);
    check("R3", {carry_out, result}, 5'b0_0000);
    apply(1'b1, 2'b11, 4'hA, 4'h5);
    check("R6", {carry_out, result}, 5'b0_0000);
    // R4/R5: the value of opb has no effect on a rotation
    for (int c = 2; c < 4; c++) begin
      apply(1'b0, 2'(c), 4'h6, 4'h0);
      first = {carry_out, result};
      for (int b = 1; b < N; b++) begin
        apply(1'b0, 2'(c), 4'h6, W'(b));
        check(c == 2 ? "R4" : "R5", {carry_out, result}, first);
      end
    end
    // Exhaustive sweep over all operations and operand pairs
    for (int g = 0; g < 2; g++)
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < N; a++)
          for (int b = 0; b < N; b++)
            apply(1'(g), 2'(c), W'(a), W'(b));
    // Constrained random patterns
    for (int k = 0; k < 600; k++)
      apply(1'($urandom), 2'($urandom), W'($urandom), W'($urandom));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule